// File: doc/BRIEF.md
# SD card clock divider with two cascaded stages

This block derives an SD card interface clock and a faster auxiliary clock from one reference clock. The ratio is set by two coded stages in series. A power-of-two pre-divider sets the auxiliary clock rate. A final stage of 2 or 4 sits on top of it and sets the card clock rate. The two clocks can be stopped independently. The reference `clk_i` runs at twice the nominal source rate, so one source period equals two `clk_i` cycles. Every output is a registered square wave with a 50 % duty cycle: the high and low phases each last "ratio" `clk_i` cycles.

Software drives the block through a single 32-bit control word on a plain write-strobe/read-data port. In one write it sets both divide codes and both stop bits, and the upper bits of the word are stored as written. A write that carries a reserved code is discarded, and a sticky error flag records it. Starting, stopping and ratio changes are applied only at the end of a low phase. As a result no shortened high phase ever reaches an output.

Top module: `sd_clk_div_top`

## Requirements
- R1: After reset the control word reads 0x0000_0301 (pre code 0, final code 1, both stop bits set). `card_clk_o`, `aux_clk_o`, `enabled_o` and `code_err_o` are all 0.
- R2: A write with legal codes stores all 32 bits. The value is visible on `reg_rdata_o` from the clock edge that takes the write.
- R3: Bits 4:2 hold the pre code. Codes 0..4 select a pre-divide of 1, 2, 4, 8 or 16, and the auxiliary clock has high and low phases of that many `clk_i` cycles each.
- R4: Bits 1:0 hold the final code. Code 0 selects 2 and code 1 selects 4. Each card clock phase lasts pre-divide times final-divide `clk_i` cycles, which gives ratios from 2 to 64.
- R5: Bit 8 set holds `card_clk_o` low, and bit 9 set holds `aux_clk_o` low. Each bit affects only its own output.
- R6: `enabled_o` is 1 exactly when bits 9 and 8 of the stored word are both 0.
- R7: A write whose pre code is 5, 6 or 7, or whose final code is 2 or 3, leaves the stored word and the running ratio unchanged. It sets `code_err_o`, which stays set until reset.
- R8: A stop, start or ratio change takes effect only at the end of a low phase. Every high phase lasts exactly the half-period of a legal ratio.
- R9: A stopped output stays low. After a start, the output rises after one full low phase of the new ratio: 65 sampled cycles after a write that starts the card clock at ratio 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the source rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word to write |
| reg_rdata_o | output | 32 | Stored control word |
| card_clk_o | output | 1 | Divided card clock |
| aux_clk_o | output | 1 | Pre-divided auxiliary clock |
| enabled_o | output | 1 | Both stop bits clear |
| code_err_o | output | 1 | Sticky flag for a rejected reserved code |

## Verification
All ten legal code pairs are applied. The phase lengths of both outputs are measured in each case, so an error in either stage's decode, or in how the two stages combine, shows up as a wrong count. Stop patterns are applied one bit at a time and then both together. This separates the two gates from each other and from the enable flag. Reserved codes in each field in turn show that the word and the ratio are held. A write that jumps from ratio 64 to ratio 2 in the middle of a high phase, together with a restart from the stopped state, probes the phase-boundary handoff for runt pulses and checks the exact start latency.

// File: rtl/sd_div_pkg.sv
package sd_div_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned STOP_AUX_BIT  = 9;
  localparam int unsigned STOP_CARD_BIT = 8;
  localparam int unsigned PRE_LSB       = 2;
  localparam int unsigned PRE_W         = 3;
  localparam int unsigned FIN_LSB       = 0;
  localparam int unsigned FIN_W         = 2;
  localparam int unsigned PRE_CODES     = 5;
  localparam int unsigned FIN_CODES     = 2;
  // largest half-period exponent: pre 4 plus final 1 plus 1
  localparam int unsigned MAX_EXP       = (PRE_CODES - 1) + (FIN_CODES - 1) + 1;
  localparam int unsigned HALF_W        = MAX_EXP + 1;
  localparam int unsigned N_STAGES      = 2;
  localparam int unsigned AUX_IDX       = 0;
  localparam int unsigned CARD_IDX      = 1;
  localparam logic [REG_W-1:0] RESET_WORD = 32'h0000_0301;

  typedef struct packed {
    logic             stop_aux;
    logic             stop_card;
    logic [PRE_W-1:0] pre;
    logic [FIN_W-1:0] fin;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [REG_W-1:0] w);
    ctl_t c;
    c.stop_aux  = w[STOP_AUX_BIT];
    c.stop_card = w[STOP_CARD_BIT];
    c.pre       = w[PRE_LSB +: PRE_W];
    c.fin       = w[FIN_LSB +: FIN_W];
    return c;
  endfunction

  function automatic logic code_ok(input ctl_t c);
    return (32'(c.pre) < PRE_CODES) && (32'(c.fin) < FIN_CODES);
  endfunction

  function automatic logic [HALF_W-1:0] aux_half(input ctl_t c);
    return HALF_W'(1) << c.pre;
  endfunction

  function automatic logic [HALF_W-1:0] card_half(input ctl_t c);
    return HALF_W'(1) << (32'(c.pre) + 32'(c.fin) + 1);
  endfunction
endpackage

// File: rtl/sd_div_regs.sv
module sd_div_regs
  import sd_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ctl_t             ctl_o,
  output logic             err_o
);
  logic [REG_W-1:0] word_q;
  logic             err_q;
  logic             wr_ok;

  assign wr_ok = code_ok(unpack_ctl(wdata_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= RESET_WORD;
      err_q  <= 1'b0;
    end else if (we_i) begin
      if (wr_ok) word_q <= wdata_i;
      else       err_q  <= 1'b1;
    end
  end

  assign rdata_o = word_q;
  assign ctl_o   = unpack_ctl(word_q);
  assign err_o   = err_q;

  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_ok) |=> (word_q == $past(word_q))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R7
  AST_CODES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_ok(ctl_o)); // R7
endmodule

// File: rtl/sd_div_stage.sv
module sd_div_stage #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              clk_o
);
  logic              out_q, run_q, phase_end;
  logic [HALF_W-1:0] half_q, cnt_q;

  assign phase_end = (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      run_q  <= 1'b0;
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
    end else if (!run_q) begin
      out_q <= 1'b0;
      cnt_q <= '0;
      if (run_i) begin
        run_q  <= 1'b1;
        half_q <= half_i;
      end
    end else if (phase_end) begin
      cnt_q <= '0;
      if (out_q) begin
        out_q <= 1'b0;
      end else if (run_i) begin
        // settings are sampled only at the low-to-high boundary
        half_q <= half_i;
        out_q  <= 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign clk_o = out_q;

  AST_HIGH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q && $past(out_q)) |-> $stable(half_q)); // R8
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !out_q); // R5
  AST_STOP_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !$past(out_q)); // R8
endmodule

// File: rtl/sd_clk_div_top.sv
module sd_clk_div_top
  import sd_div_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        card_clk_o,
  output logic        aux_clk_o,
  output logic        enabled_o,
  output logic        code_err_o
);
  ctl_t              ctl;
  logic [N_STAGES-1:0] run_v;
  logic [N_STAGES-1:0] clk_v;
  logic [HALF_W-1:0] half_v [N_STAGES];

  sd_div_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctl_o  (ctl),
    .err_o  (code_err_o)
  );

  assign run_v[AUX_IDX]   = !ctl.stop_aux;
  assign run_v[CARD_IDX]  = !ctl.stop_card;
  assign half_v[AUX_IDX]  = aux_half(ctl);
  assign half_v[CARD_IDX] = card_half(ctl);

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    sd_div_stage #(.HALF_W(HALF_W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_v[g]),
      .half_i(half_v[g]),
      .clk_o (clk_v[g])
    );
  end

  assign aux_clk_o  = clk_v[AUX_IDX];
  assign card_clk_o = clk_v[CARD_IDX];
  assign enabled_o  = !ctl.stop_aux && !ctl.stop_card;

  AST_STOPPED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctl.stop_card) && ctl.stop_card && !$past(card_clk_o)) |-> !card_clk_o); // R5
endmodule

// File: tb/sim_sd_clk_div_top.sv
module sim_sd_clk_div_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        card, aux, en, err;

  always #2 clk = ~clk;

  sd_clk_div_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .card_clk_o(card), .aux_clk_o(aux),
    .enabled_o(en), .code_err_o(err)
  );

  int total = 0;
  int bad = 0;
  int runts = 0;
  int card_run = 0;
  int aux_run = 0;

  typedef struct {int kind; int half; string req;} item_t;
  item_t q[$];
  item_t cur;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic sel(input int k);
    return (k == 1) ? card : aux;
  endfunction

  function automatic bit legal_card(input int n);
    return n == 2 || n == 4 || n == 8 || n == 16 || n == 32 || n == 64;
  endfunction

  function automatic bit legal_aux(input int n);
    return n == 1 || n == 2 || n == 4 || n == 8 || n == 16;
  endfunction

  function automatic logic [31:0] mk(input bit sa, input bit sc, input int p, input int f);
    return 32'hA5A5_B400 | (32'(sa) << 9) | (32'(sc) << 8) | (32'(p) << 2) | 32'(f);
  endfunction

  // R8 watcher: every completed high phase must match a legal half-period
  always @(negedge clk) begin
    if (card) card_run++;
    else begin
      if (card_run != 0 && !legal_card(card_run)) runts++;
      card_run = 0;
    end
    if (aux) aux_run++;
    else begin
      if (aux_run != 0 && !legal_aux(aux_run)) runts++;
      aux_run = 0;
    end
  end

  task automatic wait_rise(input int k);
    logic p;
    p = sel(k);
    forever begin
      @(negedge clk);
      if (!p && sel(k)) break;
      p = sel(k);
    end
  endtask

  // scoreboard monitor
  initial begin
    int h, l;
    forever begin
      wait (q.size() > 0);
      cur = q[0];
      wait_rise(cur.kind);
      wait_rise(cur.kind);
      h = 1;
      forever begin
        @(negedge clk);
        if (sel(cur.kind)) h++; else break;
      end
      l = 1;
      forever begin
        @(negedge clk);
        if (!sel(cur.kind)) l++; else break;
      end
      chk({cur.req, " high"}, h, cur.half);
      chk({cur.req, " low"}, l, cur.half);
      void'(q.pop_front());
    end
  end

  task automatic push_exp(input int kind, input int half, input string req);
    item_t it;
    it.kind = kind; it.half = half; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count_high(input int n, input int k, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sel(k)) hits++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int hits, lat;
    logic [31:0] keep;
    repeat (5) @(negedge clk);
    chk("R1 word", rdata, 32'h0000_0301);
    chk("R1 card", card, 0);
    chk("R1 aux", aux, 0);
    chk("R1 en", en, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    count_high(40, 1, hits);
    chk("R9 card idle", hits, 0);
    count_high(40, 0, hits);
    chk("R9 aux idle", hits, 0);

    for (int p = 0; p < 5; p++) begin
      for (int f = 0; f < 2; f++) begin
        wr(mk(0, 0, p, f));
        chk("R2 readback", rdata, mk(0, 0, p, f));
        chk("R6 en", en, 1);
        push_exp(1, (1 << p) * (2 << f), "R4 card");
        push_exp(0, 1 << p, "R3 aux");
        drain();
      end
    end

    wr(mk(0, 1, 2, 1));
    chk("R6 en card stop", en, 0);
    repeat (200) @(negedge clk);
    count_high(150, 1, hits);
    chk("R5 card held", hits, 0);
    push_exp(0, 4, "R5 aux free");
    drain();

    wr(mk(1, 0, 1, 0));
    chk("R6 en aux stop", en, 0);
    repeat (100) @(negedge clk);
    count_high(100, 0, hits);
    chk("R5 aux held", hits, 0);
    push_exp(1, 4, "R5 card free");
    drain();

    wr(mk(1, 1, 0, 0));
    repeat (150) @(negedge clk);
    count_high(100, 1, hits);
    chk("R5 both card", hits, 0);
    count_high(100, 0, hits);
    chk("R5 both aux", hits, 0);
    chk("R6 en both", en, 0);
    chk("R7 no err yet", err, 0);

    wr(mk(0, 0, 4, 1));
    lat = 0;
    while (!card) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 start latency", lat, 65);
    keep = mk(0, 0, 4, 1);

    wr(mk(0, 0, 5, 0));
    chk("R7 pre rsvd word", rdata, keep);
    chk("R7 err set", err, 1);
    wr(mk(0, 0, 7, 1));
    chk("R7 pre7 word", rdata, keep);
    wr(mk(0, 0, 1, 2));
    chk("R7 fin rsvd word", rdata, keep);
    push_exp(1, 64, "R7 ratio held");
    drain();
    wr(mk(0, 0, 0, 0));
    chk("R7 err sticky", err, 1);
    chk("R2 after err", rdata, mk(0, 0, 0, 0));

    wr(mk(0, 0, 4, 1));
    wait_rise(1);
    repeat (20) @(negedge clk);
    wr(mk(0, 0, 0, 0));
    push_exp(1, 2, "R8 new ratio");
    drain();
    wr(mk(0, 0, 3, 0));
    repeat (7) @(negedge clk);
    wr(mk(0, 1, 3, 0));
    repeat (100) @(negedge clk);
    wr(mk(0, 0, 2, 1));
    push_exp(1, 16, "R8 restart ratio");
    drain();
    repeat (50) @(negedge clk);
    chk("R8 no runt", runts, 0);

    finish_up();
  end
endmodule